// File: doc/BRIEF.md
# Two-Unit Forwarding Register File

This block holds the integer general-purpose registers for a core that issues to two execution units every cycle. It stores 32 registers of 64 bits. Register 0 is fixed at zero. Each unit reads two operands through its own pair of read ports and retires one result through its own write port. Unit 0 carries the older instruction of an issue pair and unit 1 carries the younger one.

Operands do not wait for writeback. Every read port compares its address against the results in flight:

- the execute-stage result of each unit;
- the load-return-stage result of each unit;
- the value being written this cycle.

The read port takes the youngest match. A load still in its execute stage has no data yet. A read that resolves to such a load raises a per-port hazard flag, so that issue control can hold the consumer for the one load-delay cycle. When the hazard flag is set, the returned data is not valid.

All reads and hazard flags are combinational from the addresses and bypass inputs. Writes commit at the rising clock edge.

Top module: `dual_regfile_fwd`

## Requirements
- R1: After reset every register reads zero. A value written to a nonzero register reads back on any of the four read ports in later cycles, until the register is written again.
- R2: A read of address 0 returns zero with the hazard flag low. Writes to address 0 and bypass entries that name register 0 have no effect.
- R3: Two write ports that target different registers in the same cycle both commit.
- R4: When both write ports target the same register in the same cycle, the port-1 (younger) value is the one stored.
- R5: An execute-stage result of either unit reaches every read port in the same cycle. This covers forwarding within a unit and across units.
- R6: Forwarding priority runs from the execute stage, to the load-return stage, to the write ports, to the stored array. Within one stage, unit 1 takes precedence over unit 0.
- R7: A read whose selected source is an execute-stage entry marked as a load raises that port's hazard flag. If a younger same-stage result for that register is not a load, the flag stays low. A read with no such match never raises the flag.
- R8: Load-return-stage data of either unit is forwarded to every read port, with the hazard flag low.
- R9: Data presented on a write port is visible on a matching read port in the same cycle, before it commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 4x5 | Read addresses. Ports 0-1 serve unit 0, ports 2-3 serve unit 1 |
| rd_data | output | 4x64 | Read data after forwarding |
| rd_hazard | output | 4 | Per-port flag: operand comes from a load still in its execute stage |
| ex_vld | input | 2 | Per-unit execute-stage result valid |
| ex_load | input | 2 | Per-unit execute-stage entry is a load (data not yet present) |
| ex_rd | input | 2x5 | Per-unit execute-stage destination |
| ex_data | input | 2x64 | Per-unit execute-stage result |
| mem_vld | input | 2 | Per-unit load-return-stage result valid |
| mem_rd | input | 2x5 | Per-unit load-return destination |
| mem_data | input | 2x64 | Per-unit load-return data |
| wr_en | input | 2 | Per-unit write enable |
| wr_addr | input | 2x5 | Per-unit write address |
| wr_data | input | 2x64 | Per-unit write data |

## Verification
The bench sets up collisions for a single register across every source level.

- **Write collision.** Both write ports hit one register in the same cycle. A design that let port 0 win would keep the older value.
- **Same-stage tie.** Both units present the same destination in one stage. Getting the stage priority or the unit tie-break wrong returns a stale or older operand.
- **Register 0.** Writes and bypass entries name register 0. A design that failed to mask them would leak nonzero data out of register 0.
- **Load hazards.** The bench checks loads in the execute stage in three cases: hidden behind a younger ALU result for the same register, hiding an older ALU result, and targeting a different register. A missing or spurious hazard flag would let a consumer read unready data, or stall it for no reason.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
  parameter int unsigned NUM_UNITS   = 2;
  parameter int unsigned RD_PER_UNIT = 2;

  // Stages in forwarding priority order, youngest first
  typedef enum logic [1:0] {
    STG_EX  = 2'd0,
    STG_MEM = 2'd1,
    STG_WB  = 2'd2
  } fwd_stage_e;

  localparam int unsigned NUM_STAGES = 3;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NWP   = 2,
  parameter int unsigned NRP   = 4,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NWP-1:0]             wr_en,
  input  logic [NWP-1:0][AW-1:0]     wr_addr,
  input  logic [NWP-1:0][XLEN-1:0]   wr_data,
  input  logic [NRP-1:0][AW-1:0]     rd_addr,
  output logic [NRP-1:0][XLEN-1:0]   rd_data
);
  logic [XLEN-1:0] regs_q [1:NREGS-1];
  logic [XLEN-1:0] regs_d [1:NREGS-1];
  logic [NREGS-1:1] regs_en;

  // Next-state: the highest-numbered (youngest) writer to an entry wins
  always_comb begin
    for (int i = 1; i < NREGS; i++) begin
      regs_en[i] = 1'b0;
      regs_d[i]  = regs_q[i];
      for (int w = 0; w < NWP; w++) begin
        if (wr_en[w] && (wr_addr[w] == AW'(i))) begin
          regs_en[i] = 1'b1;
          regs_d[i]  = wr_data[w];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREGS; i++) begin
        if (regs_en[i]) regs_q[i] <= regs_d[i];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NRP; p++) begin
      rd_data[p] = '0;
      for (int i = 1; i < NREGS; i++) begin
        if (rd_addr[p] == AW'(i)) rd_data[p] = regs_q[i];
      end
    end
  end
endmodule

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned AW    = 5,
  parameter int unsigned NCAND = 6
) (
  input  logic [AW-1:0]                rd_addr,
  input  logic [XLEN-1:0]              arr_data,
  input  logic [NCAND-1:0]             cand_vld,
  input  logic [NCAND-1:0]             cand_load,
  input  logic [NCAND-1:0][AW-1:0]     cand_rd,
  input  logic [NCAND-1:0][XLEN-1:0]   cand_data,
  output logic [XLEN-1:0]              op_data,
  output logic                         op_hazard
);
  logic hit;

  // Candidates arrive ordered youngest first; the first match is taken
  always_comb begin
    hit       = 1'b0;
    op_data   = arr_data;
    op_hazard = 1'b0;
    for (int c = 0; c < NCAND; c++) begin
      if (!hit && cand_vld[c] && (cand_rd[c] == rd_addr)) begin
        hit       = 1'b1;
        op_data   = cand_data[c];
        op_hazard = cand_load[c];
      end
    end
    if (rd_addr == '0) begin
      op_data   = '0;
      op_hazard = 1'b0;
    end
  end
endmodule

// File: rtl/dual_regfile_fwd.sv
module dual_regfile_fwd #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned XLEN  = 64,
  localparam int unsigned AW     = $clog2(NREGS),
  localparam int unsigned NUNITS = rfx_pkg::NUM_UNITS,
  localparam int unsigned NRP    = NUNITS * rfx_pkg::RD_PER_UNIT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NRP-1:0][AW-1:0]       rd_addr,
  output logic [NRP-1:0][XLEN-1:0]     rd_data,
  output logic [NRP-1:0]               rd_hazard,
  input  logic [NUNITS-1:0]            ex_vld,
  input  logic [NUNITS-1:0]            ex_load,
  input  logic [NUNITS-1:0][AW-1:0]    ex_rd,
  input  logic [NUNITS-1:0][XLEN-1:0]  ex_data,
  input  logic [NUNITS-1:0]            mem_vld,
  input  logic [NUNITS-1:0][AW-1:0]    mem_rd,
  input  logic [NUNITS-1:0][XLEN-1:0]  mem_data,
  input  logic [NUNITS-1:0]            wr_en,
  input  logic [NUNITS-1:0][AW-1:0]    wr_addr,
  input  logic [NUNITS-1:0][XLEN-1:0]  wr_data
);
  import rfx_pkg::*;

  localparam int unsigned NCAND = NUM_STAGES * NUNITS;

  logic [NRP-1:0][XLEN-1:0]   arr_rd;
  logic [NCAND-1:0]           cand_vld;
  logic [NCAND-1:0]           cand_load;
  logic [NCAND-1:0][AW-1:0]   cand_rd;
  logic [NCAND-1:0][XLEN-1:0] cand_data;

  rf_store #(
    .NREGS (NREGS),
    .XLEN  (XLEN),
    .NWP   (NUNITS),
    .NRP   (NRP)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (arr_rd)
  );

  // Candidate list: stage-major, younger unit first inside a stage
  for (genvar u = 0; u < NUNITS; u++) begin : g_cand
    localparam int unsigned SLOT = NUNITS - 1 - u;
    localparam int unsigned I_EX  = int'(STG_EX)  * NUNITS + SLOT;
    localparam int unsigned I_MEM = int'(STG_MEM) * NUNITS + SLOT;
    localparam int unsigned I_WB  = int'(STG_WB)  * NUNITS + SLOT;

    assign cand_vld[I_EX]   = ex_vld[u];
    assign cand_load[I_EX]  = ex_load[u];
    assign cand_rd[I_EX]    = ex_rd[u];
    assign cand_data[I_EX]  = ex_data[u];

    assign cand_vld[I_MEM]  = mem_vld[u];
    assign cand_load[I_MEM] = 1'b0;
    assign cand_rd[I_MEM]   = mem_rd[u];
    assign cand_data[I_MEM] = mem_data[u];

    assign cand_vld[I_WB]   = wr_en[u];
    assign cand_load[I_WB]  = 1'b0;
    assign cand_rd[I_WB]    = wr_addr[u];
    assign cand_data[I_WB]  = wr_data[u];
  end

  for (genvar p = 0; p < NRP; p++) begin : g_port
    fwd_select #(
      .XLEN  (XLEN),
      .AW    (AW),
      .NCAND (NCAND)
    ) u_sel (
      .rd_addr   (rd_addr[p]),
      .arr_data  (arr_rd[p]),
      .cand_vld  (cand_vld),
      .cand_load (cand_load),
      .cand_rd   (cand_rd),
      .cand_data (cand_data),
      .op_data   (rd_data[p]),
      .op_hazard (rd_hazard[p])
    );
  end
endmodule

// File: rtl/dual_regfile_fwd_chk.sv
module dual_regfile_fwd_chk #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned XLEN  = 64,
  localparam int unsigned AW     = $clog2(NREGS),
  localparam int unsigned NUNITS = rfx_pkg::NUM_UNITS,
  localparam int unsigned NRP    = NUNITS * rfx_pkg::RD_PER_UNIT
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NRP-1:0][AW-1:0]       rd_addr,
  input logic [NRP-1:0][XLEN-1:0]     rd_data,
  input logic [NRP-1:0]               rd_hazard,
  input logic [NUNITS-1:0]            ex_vld,
  input logic [NUNITS-1:0]            ex_load,
  input logic [NUNITS-1:0][AW-1:0]    ex_rd,
  input logic [NUNITS-1:0][XLEN-1:0]  ex_data,
  input logic [NUNITS-1:0]            mem_vld,
  input logic [NUNITS-1:0][AW-1:0]    mem_rd,
  input logic [NUNITS-1:0][XLEN-1:0]  mem_data,
  input logic [NUNITS-1:0]            wr_en,
  input logic [NUNITS-1:0][AW-1:0]    wr_addr,
  input logic [NUNITS-1:0][XLEN-1:0]  wr_data
);
  localparam int unsigned YU = NUNITS - 1;

  logic [NRP-1:0] ld_match;
  logic [NRP-1:0] any_byp;

  always_comb begin
    for (int p = 0; p < NRP; p++) begin
      ld_match[p] = 1'b0;
      any_byp[p]  = 1'b0;
      for (int u = 0; u < NUNITS; u++) begin
        if (ex_vld[u] && ex_load[u] && ex_rd[u] == rd_addr[p]) ld_match[p] = 1'b1;
        if ((ex_vld[u] && ex_rd[u] == rd_addr[p]) ||
            (mem_vld[u] && mem_rd[u] == rd_addr[p]) ||
            (wr_en[u] && wr_addr[u] == rd_addr[p])) any_byp[p] = 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_chk
    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[p] == '0) |-> (rd_data[p] == '0 && !rd_hazard[p])); // R2

    AST_HAZARD_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hazard[p] |-> ld_match[p]); // R7

    AST_YOUNG_EX_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[p] != '0 && ex_vld[YU] && ex_rd[YU] == rd_addr[p])
        |-> (rd_data[p] == ex_data[YU])); // R5

    AST_WRITE_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en[0] && wr_en[YU] && wr_addr[0] == wr_addr[YU] && wr_addr[YU] != '0)
        && rd_addr[p] == $past(wr_addr[YU]) && !any_byp[p])
        |-> (rd_data[p] == $past(wr_data[YU]))); // R4
  end
endmodule

bind dual_regfile_fwd dual_regfile_fwd_chk #(.NREGS(NREGS), .XLEN(XLEN)) u_chk (.*);

// File: tb/tb_dual_regfile_fwd.sv
module tb_dual_regfile_fwd;
  localparam int AW = 5;
  localparam int XL = 64;

  logic clk;
  logic rst_n;
  logic [3:0][AW-1:0] rd_addr;
  logic [3:0][XL-1:0] rd_data;
  logic [3:0]         rd_hazard;
  logic [1:0]         ex_vld, ex_load, mem_vld, wr_en;
  logic [1:0][AW-1:0] ex_rd, mem_rd, wr_addr;
  logic [1:0][XL-1:0] ex_data, mem_data, wr_data;

  dual_regfile_fwd dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int          port;
    logic [XL-1:0] data;
    logic        hz;
    logic        chk_data;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic new_cycle();
    @(negedge clk);
    ex_vld = '0; ex_load = '0; mem_vld = '0; wr_en = '0;
  endtask

  task automatic expect_rd(int p, logic [AW-1:0] a, logic [XL-1:0] d, logic hz,
                           logic cd, string tag);
    exp_t e;
    rd_addr[p] = a;
    e.port = p; e.data = d; e.hz = hz; e.chk_data = cd; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic set_ex(int u, logic ld, logic [AW-1:0] r, logic [XL-1:0] d);
    ex_vld[u] = 1'b1; ex_load[u] = ld; ex_rd[u] = r; ex_data[u] = d;
  endtask

  task automatic set_mem(int u, logic [AW-1:0] r, logic [XL-1:0] d);
    mem_vld[u] = 1'b1; mem_rd[u] = r; mem_data[u] = d;
  endtask

  task automatic set_wr(int u, logic [AW-1:0] r, logic [XL-1:0] d);
    wr_en[u] = 1'b1; wr_addr[u] = r; wr_data[u] = d;
  endtask

  // Monitor: compare queued expectations once inputs have settled
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if ((e.chk_data && rd_data[e.port] !== e.data) || rd_hazard[e.port] !== e.hz) begin
          errors++;
          $display("FAIL %s port %0d data %h exp %h hazard %b exp %b",
                   e.tag, e.port, rd_data[e.port], e.data, rd_hazard[e.port], e.hz);
        end
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rd_addr = '0; ex_vld = '0; ex_load = '0; ex_rd = '0; ex_data = '0;
    mem_vld = '0; mem_rd = '0; mem_data = '0;
    wr_en = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    new_cycle();
    expect_rd(0, 5'd5, '0, 0, 1, "R1 reset");
    expect_rd(1, 5'd31, '0, 0, 1, "R1 reset");
    expect_rd(2, 5'd1, '0, 0, 1, "R1 reset");
    expect_rd(3, 5'd0, '0, 0, 1, "R1 reset");

    // R9 write-through, R3 distinct writes
    new_cycle();
    set_wr(0, 5'd3, 64'hA0A0_0000_0000_0003);
    set_wr(1, 5'd7, 64'hB0B0_0000_0000_0007);
    expect_rd(0, 5'd3, 64'hA0A0_0000_0000_0003, 0, 1, "R9 wb0");
    expect_rd(3, 5'd7, 64'hB0B0_0000_0000_0007, 0, 1, "R9 wb1");

    new_cycle();
    expect_rd(1, 5'd3, 64'hA0A0_0000_0000_0003, 0, 1, "R3 store0");
    expect_rd(2, 5'd7, 64'hB0B0_0000_0000_0007, 0, 1, "R3 store1");

    // R4 write collision
    new_cycle();
    set_wr(0, 5'd9, 64'hC);
    set_wr(1, 5'd9, 64'hD);
    expect_rd(0, 5'd9, 64'hD, 0, 1, "R6 wb tie");
    new_cycle();
    expect_rd(0, 5'd9, 64'hD, 0, 1, "R4 collide");
    expect_rd(2, 5'd3, 64'hA0A0_0000_0000_0003, 0, 1, "R1 hold");

    // R2 register zero
    new_cycle();
    set_wr(0, 5'd0, 64'hFF);
    set_ex(1, 1'b1, 5'd0, 64'hEE);
    set_mem(0, 5'd0, 64'hDD);
    expect_rd(0, 5'd0, '0, 0, 1, "R2 bypass r0");
    new_cycle();
    expect_rd(2, 5'd0, '0, 0, 1, "R2 write r0");

    // R5 execute forwarding within and across units
    new_cycle();
    set_ex(0, 1'b0, 5'd4, 64'hE0);
    set_ex(1, 1'b0, 5'd5, 64'hE1);
    expect_rd(3, 5'd4, 64'hE0, 0, 1, "R5 cross");
    expect_rd(2, 5'd5, 64'hE1, 0, 1, "R5 within");
    expect_rd(0, 5'd5, 64'hE1, 0, 1, "R5 cross");

    // R6 priority
    new_cycle();
    set_ex(0, 1'b0, 5'd6, 64'h60);
    set_ex(1, 1'b0, 5'd6, 64'h61);
    set_mem(1, 5'd6, 64'h71);
    set_wr(0, 5'd6, 64'h99);
    expect_rd(1, 5'd6, 64'h61, 0, 1, "R6 ex tie");
    new_cycle();
    set_mem(0, 5'd6, 64'h70);
    set_mem(1, 5'd6, 64'h71);
    set_wr(0, 5'd6, 64'h99);
    expect_rd(1, 5'd6, 64'h71, 0, 1, "R6 mem tie");
    new_cycle();
    set_mem(0, 5'd8, 64'h88);
    expect_rd(3, 5'd8, 64'h88, 0, 1, "R8 mem cross");
    expect_rd(0, 5'd6, 64'h99, 0, 1, "R1 stored");

    // R7 load hazard then R8 load return
    new_cycle();
    set_ex(0, 1'b1, 5'd12, 64'h0);
    expect_rd(0, 5'd12, '0, 1, 0, "R7 hazard");
    expect_rd(3, 5'd12, '0, 1, 0, "R7 hazard");
    expect_rd(1, 5'd16, '0, 0, 1, "R7 unrelated");
    new_cycle();
    set_mem(0, 5'd12, 64'h1212);
    expect_rd(0, 5'd12, 64'h1212, 0, 1, "R8 load data");

    new_cycle();
    set_ex(0, 1'b1, 5'd13, 64'h0);
    set_ex(1, 1'b0, 5'd13, 64'h1313);
    expect_rd(0, 5'd13, 64'h1313, 0, 1, "R7 younger alu");
    new_cycle();
    set_ex(0, 1'b0, 5'd14, 64'h1414);
    set_ex(1, 1'b1, 5'd14, 64'h0);
    expect_rd(2, 5'd14, '0, 1, 0, "R7 younger load");

    new_cycle();
    new_cycle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule